// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus with an address, a write strobe, a read strobe, write data and read data. A down-counter is loaded from one of sixteen power-of-two periods. Software must keep the counter from running out by writing a fixed code to a restart register. Once the enable bit is set, software cannot clear it. Only a block reset disables the watchdog again.

The block has two response modes. In the direct mode, the first time the counter runs out it drives a system-reset pulse. In the two-stage mode, the first time the counter runs out it raises an interrupt and reloads the counter. If the counter runs out a second time with no restart in between, the system-reset pulse follows. After the pulse the counter stays stopped until the block itself is reset.

The control logic is a five-state machine:
- `WS_IDLE`: disabled.
- `WS_ARMED`: counting, no interrupt stage taken.
- `WS_WARNED`: counting the second period in two-stage mode.
- `WS_BITE`: the reset pulse is being driven.
- `WS_HALT`: stopped after the pulse.

Its transitions are:
- enable write: `WS_IDLE` to `WS_ARMED`.
- valid restart: `WS_ARMED` or `WS_WARNED` to `WS_ARMED`.
- run-out in two-stage mode: `WS_ARMED` to `WS_WARNED`.
- run-out in direct mode: `WS_ARMED` to `WS_BITE`.
- second run-out: `WS_WARNED` to `WS_BITE`.
- pulse complete: `WS_BITE` to `WS_HALT`.

Top module: `watchdog_timer`

## Requirements
- R1: After reset, the block is disabled. Control, range, count and status registers read 0, and both `irq_o` and `sys_rst_o` are low.
- R2: Register offsets are: control at 0x00, range at 0x04, count at 0x08, restart at 0x0C, interrupt status at 0x10, interrupt clear at 0x14, parameter at 0xF4. The parameter register reads 0x40, where bit 6 set means the fixed power-of-two table is in use. Unmapped offsets read 0.
- R3: In the control register, bit 0 is enable and bit 1 is mode (1 = two-stage). Once enable is set, it reads back 1 and cannot be cleared by a write. Only a block reset clears it.
- R4: Period index i selects a count of 2^(PERIOD_BASE+i) clocks, for i from 0 to 15.
- R5: In the range register, bits 3:0 are the active index and bits 7:4 are the initial index. Setting enable loads the counter from the initial index.
- R6: Writing exactly 0x76 to the restart register while counting reloads the counter from the active index. Any other value has no effect. Writes while disabled or halted have no effect.
- R7: The count register returns the live counter. The counter holds the loaded value P in the clock after the load and decreases by one every clock after that, so it runs out P clocks after the load.
- R8: In direct mode, running out starts the reset pulse in the same clock edge. `sys_rst_o` is only ever high while the block is enabled.
- R9: In two-stage mode, the first run-out sets the interrupt and reloads the active period without a reset. A second run-out with no restart starts the reset pulse, 2P clocks after the load.
- R10: The interrupt stays set until a valid restart or a read of the interrupt clear register, which returns the status. A clear read does not reload the counter.
- R11: The reset pulse lasts RST_PULSE clocks. Afterwards the count reads 0 and restart writes have no effect until a block reset.
- R12: Bit 0 of the interrupt status register mirrors the pending interrupt, and reading it does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low block reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; needed for the clear-on-read register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | First-stage interrupt, level |
| sys_rst_o | output | 1 | System-reset pulse |

## Verification
The bench builds the block with PERIOD_BASE = 2 and RST_PULSE = 5. With these values the shortest periods are 4 to 2048 clocks, so the bench can time every run-out exactly. It sweeps the low ten indices in direct mode and the low five in two-stage mode. The longest index, 2^17, is checked by reading back its loaded count rather than by waiting for it to run out. The short reset pulse keeps the pulse-length check and the check that the block stays stopped afterwards quick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ARMED,
        WS_WARNED,
        WS_BITE,
        WS_HALT
    } wdt_state_e;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_RANGE = 8'h04;
    localparam logic [7:0] A_COUNT = 8'h08;
    localparam logic [7:0] A_KICK  = 8'h0C;
    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_ICLR  = 8'h14;
    localparam logic [7:0] A_PARAM = 8'hF4;

    localparam logic [31:0] KICK_CODE = 32'h0000_0076;
    localparam logic [31:0] PARAM_VAL = 32'h0000_0040;

    localparam int NUM_PERIODS = 16;
    localparam int IDX_W       = 4;
endpackage

// File: rtl/wdt_period.sv
module wdt_period
    import wdt_pkg::*;
#(
    parameter int PERIOD_BASE = 16,
    parameter int CNT_W       = PERIOD_BASE + 16
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] period
);
    logic [CNT_W-1:0] table_w [NUM_PERIODS];

    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_tbl
        assign table_w[g] = CNT_W'(1) << (PERIOD_BASE + g);
    end

    assign period = table_w[idx];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enabled,
    input  logic              irq,
    input  logic [CNT_W-1:0]  cnt,
    output logic              mode,
    output logic [IDX_W-1:0]  act_idx,
    output logic [IDX_W-1:0]  init_idx,
    output logic              en_set,
    output logic              kick,
    output logic              irq_clr
);
    logic       mode_q;
    logic [7:0] range_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            range_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL)  mode_q  <= bus_wdata[1];
            if (bus_addr == A_RANGE) range_q <= bus_wdata[7:0];
        end
    end

    assign mode     = mode_q;
    assign act_idx  = range_q[3:0];
    assign init_idx = range_q[7:4];
    assign en_set   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
    assign kick     = bus_wr && (bus_addr == A_KICK) && (bus_wdata == DATA_W'(KICK_CODE));
    assign irq_clr  = bus_rd && (bus_addr == A_ICLR);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'({mode_q, enabled});
            A_RANGE: bus_rdata = DATA_W'(range_q);
            A_COUNT: bus_rdata = DATA_W'(cnt);
            A_STAT:  bus_rdata = DATA_W'(irq);
            A_ICLR:  bus_rdata = DATA_W'(irq);
            A_PARAM: bus_rdata = DATA_W'(PARAM_VAL);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int RST_PULSE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             kick,
    input  logic             irq_clr,
    input  logic             mode,
    input  logic [CNT_W-1:0] init_period,
    input  logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             sys_rst,
    output logic             enabled,
    output logic             run
);
    localparam int PC_W = $clog2(RST_PULSE + 1);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  pc_q;
    logic             irq_q;
    logic             expire;

    assign run    = (state_q == WS_ARMED) || (state_q == WS_WARNED);
    assign expire = run && (cnt_q == CNT_W'(1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (en_set) state_d = WS_ARMED;
            WS_ARMED: begin
                if (kick)        state_d = WS_ARMED;
                else if (expire) state_d = mode ? WS_WARNED : WS_BITE;
            end
            WS_WARNED: begin
                if (kick)        state_d = WS_ARMED;
                else if (expire) state_d = WS_BITE;
            end
            WS_BITE:   if (pc_q == PC_W'(RST_PULSE - 1)) state_d = WS_HALT;
            WS_HALT:   state_d = WS_HALT;
            default:   state_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // counter, pulse timer and interrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pc_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (state_q == WS_IDLE) begin
                if (en_set) cnt_q <= init_period;
            end else if (run) begin
                if (kick)        cnt_q <= act_period;
                else if (expire) cnt_q <= (state_q == WS_ARMED && mode) ? act_period : '0;
                else             cnt_q <= cnt_q - CNT_W'(1);
            end else if (state_q == WS_BITE) begin
                pc_q <= pc_q + PC_W'(1);
            end

            if (run && kick)                                irq_q <= 1'b0;
            else if (state_q == WS_ARMED && expire && mode) irq_q <= 1'b1;
            else if (irq_clr)                               irq_q <= 1'b0;
        end
    end

    // Moore outputs
    always_comb begin
        cnt     = cnt_q;
        irq     = irq_q;
        sys_rst = (state_q == WS_BITE);
        enabled = (state_q != WS_IDLE);
    end
endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
    import wdt_pkg::*;
#(
    parameter int PERIOD_BASE = 16,
    parameter int RST_PULSE   = 8,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam int CNT_W = PERIOD_BASE + NUM_PERIODS;

    logic             mode, en_set, kick, irq_clr;
    logic [IDX_W-1:0] act_idx, init_idx;
    logic [CNT_W-1:0] act_period, init_period, cnt;
    logic             irq, sys_rst, enabled, run;

    wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enabled(enabled), .irq(irq), .cnt(cnt), .mode(mode),
        .act_idx(act_idx), .init_idx(init_idx), .en_set(en_set),
        .kick(kick), .irq_clr(irq_clr)
    );

    wdt_period #(.PERIOD_BASE(PERIOD_BASE), .CNT_W(CNT_W)) u_act_per (
        .idx(act_idx), .period(act_period)
    );

    wdt_period #(.PERIOD_BASE(PERIOD_BASE), .CNT_W(CNT_W)) u_init_per (
        .idx(init_idx), .period(init_period)
    );

    wdt_fsm #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .kick(kick),
        .irq_clr(irq_clr), .mode(mode), .init_period(init_period),
        .act_period(act_period), .cnt(cnt), .irq(irq), .sys_rst(sys_rst),
        .enabled(enabled), .run(run)
    );

    assign irq_o     = irq;
    assign sys_rst_o = sys_rst;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  act_period,
    input logic              enabled,
    input logic              run
);
    logic good_kick, bad_kick, clr_rd;
    assign good_kick = bus_wr && bus_addr == A_KICK && bus_wdata == DATA_W'(KICK_CODE);
    assign bad_kick  = bus_wr && bus_addr == A_KICK && bus_wdata != DATA_W'(KICK_CODE);
    assign clr_rd    = bus_rd && bus_addr == A_ICLR;

    p_param_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_PARAM) |-> (bus_rdata == DATA_W'(PARAM_VAL)));

    p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |=> enabled);

    p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (good_kick && run) |=> (cnt == $past(act_period)));

    p_bad_kick_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_kick && run && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_rst_when_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> enabled);

    p_irq_first_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!sys_rst_o && run));

    p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(good_kick && run) && !clr_rd) |=> irq_o);
endmodule

bind watchdog_timer wdt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o), .cnt(cnt), .act_period(act_period),
    .enabled(enabled), .run(run)
);

// File: tb/watchdog_timer_bench.sv
module watchdog_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;
    localparam int PULSE      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int checks = 0;
    int errors = 0;

    watchdog_timer #(.PERIOD_BASE(BASE), .RST_PULSE(PULSE)) u_watchdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint per(int i);
        return longint'(1) << (BASE + i);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rst(output int n);
        n = 0;
        while (!sys_rst_o && n < 10000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_o && n < 10000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int n, k;

        // R1 reset state
        do_reset();
        rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
        rd(8'h04, d); check(d == 0, "R1 range", d, 0);
        rd(8'h08, d); check(d == 0, "R1 count", d, 0);
        rd(8'h10, d); check(d == 0, "R1 status", d, 0);
        check(!irq_o && !sys_rst_o, "R1 outputs", {irq_o, sys_rst_o}, 0);

        // R2 parameter and unmapped
        rd(8'hF4, d); check(d == 32'h40, "R2 param", d, 32'h40);
        rd(8'h20, d); check(d == 0, "R2 unmapped", d, 0);

        // R6 restart while disabled has no effect
        wr(8'h0C, 32'h76);
        repeat (50) @(negedge clk);
        rd(8'h08, d); check(d == 0, "R6 kick while idle", d, 0);
        check(!sys_rst_o, "R6 no reset while idle", sys_rst_o, 0);

        // R4 R7 R8 R11 direct-mode sweep
        for (int i = 0; i < 10; i++) begin
            do_reset();
            wr(8'h04, {24'b0, 4'(i), 4'(i)});
            wr(8'h00, 32'h1);
            rd(8'h08, d); check(d == per(i), "R7 loaded count", d, per(i));
            wait_rst(n); check(longint'(n) == per(i) - 1, "R4 R8 direct period", n, per(i) - 1);
            k = 0;
            while (sys_rst_o && k < 100) begin @(negedge clk); k++; end
            check(k == PULSE, "R11 pulse length", k, PULSE);
        end
        wr(8'h0C, 32'h76);
        repeat (20) @(negedge clk);
        check(!sys_rst_o, "R11 halted no reset", sys_rst_o, 0);
        rd(8'h08, d); check(d == 0, "R11 halted count", d, 0);

        // R4 longest period by load value
        do_reset();
        wr(8'h04, 32'hFF); wr(8'h00, 32'h1);
        rd(8'h08, d); check(d == per(15), "R4 index 15", d, per(15));

        // R5 initial vs active index
        do_reset();
        wr(8'h04, 32'h13); wr(8'h00, 32'h1);
        rd(8'h08, d); check(d == per(1), "R5 initial load", d, per(1));
        wr(8'h0C, 32'h76);
        rd(8'h08, d); check(d == per(3), "R5 R6 active reload", d, per(3));
        wait_rst(n); check(longint'(n) == per(3) - 1, "R6 period after restart", n, per(3) - 1);

        // R6 wrong codes ignored, R7 live decrement
        do_reset();
        wr(8'h04, 32'h22); wr(8'h00, 32'h1);
        rd(8'h08, d);
        wr(8'h0C, 32'h75);
        rd(8'h08, d2); check(d2 == d - 2, "R6 bad code 0x75", d2, d - 2);
        wr(8'h0C, 32'h176);
        rd(8'h08, d); check(d == d2 - 2, "R6 bad code 0x176", d, d2 - 2);

        // R3 sticky enable
        do_reset();
        wr(8'h04, 32'h33); wr(8'h00, 32'h1); wr(8'h00, 32'h0);
        rd(8'h00, d); check(d[0] == 1'b1, "R3 enable sticky", d[0], 1);
        wait_rst(n); check(sys_rst_o, "R3 still bites", sys_rst_o, 1);

        // R9 R10 R12 two-stage sweep
        for (int i = 0; i < 5; i++) begin
            do_reset();
            wr(8'h04, {24'b0, 4'(i), 4'(i)});
            wr(8'h00, 32'h3);
            wait_irq(n); check(longint'(n) == per(i), "R9 first stage", n, per(i));
            check(!sys_rst_o, "R9 no reset at first stage", sys_rst_o, 0);
            rd(8'h10, d); check(d == 1, "R12 status set", d, 1);
            wait_rst(n); check(longint'(n) == per(i) - 1, "R9 second stage", n, per(i) - 1);
            check(irq_o, "R10 irq held to reset", irq_o, 1);
        end

        // R10 clear by read
        do_reset();
        wr(8'h04, 32'h33); wr(8'h00, 32'h3);
        wait_irq(n);
        rd(8'h14, d); check(d == 1, "R10 clear read value", d, 1);
        check(!irq_o, "R10 irq cleared", irq_o, 0);
        rd(8'h10, d); check(d == 0, "R12 status after clear", d, 0);
        wait_rst(n); check(longint'(n) == per(3) - 2, "R10 clear keeps counter", n, per(3) - 2);

        // R10 restart in second stage
        do_reset();
        wr(8'h04, 32'h22); wr(8'h00, 32'h3);
        wait_irq(n);
        wr(8'h0C, 32'h76);
        check(!irq_o, "R10 restart clears irq", irq_o, 0);
        rd(8'h08, d); check(d == per(2), "R10 restart reload", d, per(2));
        wait_irq(n); check(longint'(n) == per(2) - 1, "R9 new first stage", n, per(2) - 1);
        check(!sys_rst_o, "R9 no reset after restart", sys_rst_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule